// File: doc/BRIEF.md
# Flit Transaction Completion Tracker

This block follows multi-flit memory transactions as their flits come in. Each flit carries a transaction tag, first and last markers, and the commit finish time that the channel scheduler has already assigned to it. For every open tag the tracker keeps the latest finish time seen so far. When the closing flit arrives, the tag's entry is retired into a small pending-response queue. The entry waits there until the free-running cycle count reaches its finish time, and intake of new flits goes on in the meantime. Because release is separate from intake, single-flit transactions that complete on different channels overlap rather than queue up one behind another.

When an entry is released, the tracker produces a response description. Its kind depends on the request class, the direction and whether the transaction came over a bypass path. It is steered to the first hop of the recorded reverse path, or marked for direct completion when that path is too short. The first flit of a tag carries the context that the response needs: class, bypass flag, direction, byte count, the requester identity word, path length and first reverse hop.

Top module: `flit_done_tracker`

## Requirements
- R1: On a tag's first flit, the tag's running finish time starts at the current cycle count plus a fixed decode overhead `OVH_CYC` (default 2). It is then raised to that flit's finish if the flit's finish is later.
- R2: Each later flit of an open tag raises the tag's running finish time to the flit's finish when that value is larger, and never lowers it.
- R3: A flit with the last marker removes its tag's entry. If the flit is accepted at cycle count T, the response appears in `rsp_valid` for one cycle at cycle count max(running finish, T+1) + 1, carrying the tag in `rsp_tag`.
- R4: Pending responses do not hold back intake. While the pending queue has room, `fl_ready` stays high, so single-flit transactions can be accepted on consecutive cycles.
- R5: A DMA-class request (`fl_dma`=1, which takes priority over everything else) gives `rsp_kind`=0, with `rsp_len`=0 and `rsp_ids`=0.
- R6: A non-DMA bypass read (`fl_bypass`=1, `fl_write`=0) gives `rsp_kind`=1, with `rsp_len` equal to the requested byte count.
- R7: A non-DMA bypass write gives `rsp_kind`=2. It completes locally: `rsp_fwd`=0 and `rsp_hop`=0.
- R8: Any other request gives `rsp_kind`=3 (success status), with `rsp_ids` equal to the requester identity word and `rsp_len`=0.
- R9: A response of kind 0, 1 or 3 is sent to the reverse hop (`rsp_fwd`=1, `rsp_hop`=`fl_next_hop`) when the recorded path length `fl_hops` is at least 2. Otherwise it completes directly (`rsp_fwd`=0, `rsp_hop`=0).
- R10: When all `DEPTH` tag entries are occupied, a first flit that is not also last is refused (`fl_ready`=0). Continuation flits of open tags are still accepted.
- R11: The queue releases at most one response per cycle, always the due entry with the smallest finish time. Two entries with equal finish times come out on consecutive cycles.
- R12: After reset, `fl_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fl_valid | input | 1 | Flit present |
| fl_ready | output | 1 | Flit accepted this cycle when valid |
| fl_tag | input | TAG_W | Transaction tag |
| fl_first | input | 1 | First flit of its transaction |
| fl_last | input | 1 | Last flit of its transaction |
| fl_finish | input | T_W | Scheduler commit finish time for this flit |
| fl_dma | input | 1 | DMA-class request (first flit) |
| fl_bypass | input | 1 | Request arrived over a bypass path (first flit) |
| fl_write | input | 1 | Write direction (first flit) |
| fl_nbytes | input | LEN_W | Requested byte count (first flit) |
| fl_ids | input | ID_W | Requester identity word: correlation, request id, cube, PE (first flit) |
| fl_hops | input | PLEN_W | Recorded reverse path length (first flit) |
| fl_next_hop | input | HOP_W | First reverse hop (first flit) |
| rsp_valid | output | 1 | Response released this cycle |
| rsp_kind | output | 2 | 0 DMA ack, 1 read data, 2 local done, 3 status |
| rsp_fwd | output | 1 | Response goes to a reverse hop |
| rsp_hop | output | HOP_W | Reverse hop, 0 when not forwarded |
| rsp_len | output | LEN_W | Data byte count, nonzero only for kind 1 |
| rsp_ids | output | ID_W | Identity word, nonzero only for kind 3 |
| rsp_tag | output | TAG_W | Completion handle (transaction tag) |

## Verification
The hardest state to reach is a pending queue holding several retired transactions whose finish times are out of arrival order, or equal, while new flits keep arriving. This requires back-to-back single-flit transactions with finish offsets chosen so that a later arrival comes due first and two others come due in the same cycle. A second hard case is a full tag table: four transactions are left open, a fifth first flit is presented and must be refused, and a continuation flit then frees a slot. A vector table covers the response kinds and path lengths, and directed sequences cover the timing cases.

// File: rtl/fct_pkg.sv
package fct_pkg;

   typedef enum logic [1:0] {
      RK_DMA    = 2'd0,
      RK_RDATA  = 2'd1,
      RK_LOCAL  = 2'd2,
      RK_STATUS = 2'd3
   } rsp_kind_e;

   // DMA class wins, then bypass read/write, otherwise a status message.
   function automatic rsp_kind_e pick_kind(input logic dma, input logic byp, input logic wr);
      if (dma)      return RK_DMA;
      else if (byp) return wr ? RK_LOCAL : RK_RDATA;
      else          return RK_STATUS;
   endfunction

endpackage

// File: rtl/fct_tag_table.sv
module fct_tag_table #(
   parameter int TAG_W   = 4,
   parameter int DEPTH   = 4,
   parameter int T_W     = 16,
   parameter int CTX_W   = 40,
   parameter int OVH_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [T_W-1:0]   now,
   input  logic             acc,
   input  logic [TAG_W-1:0] tag,
   input  logic             first,
   input  logic             last,
   input  logic [T_W-1:0]   fin,
   input  logic [CTX_W-1:0] ctx_in,
   output logic             full,
   output logic [T_W-1:0]   ret_fin,
   output logic [CTX_W-1:0] ret_ctx
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("fct_tag_table: DEPTH must be at least 2");
   end
   if (OVH_CYC < 0) begin : g_bad_ovh
      $error("fct_tag_table: OVH_CYC must not be negative");
   end

   logic             ent_v   [DEPTH];
   logic [TAG_W-1:0] ent_tag [DEPTH];
   logic [T_W-1:0]   ent_lf  [DEPTH];
   logic [CTX_W-1:0] ent_ctx [DEPTH];

   logic [DEPTH-1:0] hit;
   logic [DEPTH-1:0] busy;
   logic [IDX_W-1:0] hit_idx, free_idx;
   logic [T_W-1:0]   base_lf;

   for (genvar g = 0; g < DEPTH; g++) begin : g_match
      assign hit[g]  = ent_v[g] && (ent_tag[g] == tag);
      assign busy[g] = ent_v[g];
   end

   assign full = &busy;

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (hit[i]) hit_idx = IDX_W'(i);
      end
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!busy[i]) free_idx = IDX_W'(i);
      end
   end

   assign base_lf = first ? (now + T_W'(OVH_CYC)) : ent_lf[hit_idx];
   assign ret_fin = (fin > base_lf) ? fin : base_lf;
   assign ret_ctx = first ? ctx_in : ent_ctx[hit_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            ent_v[i]   <= 1'b0;
            ent_tag[i] <= '0;
            ent_lf[i]  <= '0;
            ent_ctx[i] <= '0;
         end
      end else if (acc) begin
         if (first && !last) begin
            ent_v[free_idx]   <= 1'b1;
            ent_tag[free_idx] <= tag;
            ent_lf[free_idx]  <= ret_fin;
            ent_ctx[free_idx] <= ctx_in;
         end else if (!first) begin
            if (last) ent_v[hit_idx]  <= 1'b0;
            else      ent_lf[hit_idx] <= ret_fin;
         end
      end
   end

   AST_CONT_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !first) |-> (|hit)); // R2

   AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && first && !last) |-> !full); // R10

   for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      AST_LF_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         (ent_v[g] && $past(ent_v[g])) |-> (ent_lf[g] >= $past(ent_lf[g]))); // R2
   end

endmodule

// File: rtl/fct_rsp_queue.sv
module fct_rsp_queue #(
   parameter int QDEPTH = 4,
   parameter int T_W    = 16,
   parameter int CTX_W  = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [T_W-1:0]   now,
   input  logic             push,
   input  logic [T_W-1:0]   push_fin,
   input  logic [CTX_W-1:0] push_ctx,
   output logic             full,
   output logic             rel_valid,
   output logic [CTX_W-1:0] rel_ctx
);
   localparam int QI_W = $clog2(QDEPTH);

   if (QDEPTH < 2) begin : g_bad_qdepth
      $error("fct_rsp_queue: QDEPTH must be at least 2");
   end

   logic             q_v   [QDEPTH];
   logic [T_W-1:0]   q_fin [QDEPTH];
   logic [CTX_W-1:0] q_ctx [QDEPTH];
   logic [QDEPTH-1:0] busy;

   logic            due;
   logic [QI_W-1:0] sel, free_idx;
   logic [T_W-1:0]  best;
   logic [T_W-1:0]  rel_fin;

   for (genvar g = 0; g < QDEPTH; g++) begin : g_busy
      assign busy[g] = q_v[g];
   end
   assign full = &busy;

   // Earliest due entry; strict compare keeps the lowest slot on ties.
   always_comb begin
      due      = 1'b0;
      sel      = '0;
      best     = '0;
      free_idx = '0;
      for (int i = 0; i < QDEPTH; i++) begin
         if (q_v[i] && (q_fin[i] <= now) && (!due || (q_fin[i] < best))) begin
            due  = 1'b1;
            sel  = QI_W'(i);
            best = q_fin[i];
         end
      end
      for (int i = QDEPTH - 1; i >= 0; i--) begin
         if (!q_v[i]) free_idx = QI_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < QDEPTH; i++) begin
            q_v[i]   <= 1'b0;
            q_fin[i] <= '0;
            q_ctx[i] <= '0;
         end
         rel_valid <= 1'b0;
         rel_ctx   <= '0;
         rel_fin   <= '0;
      end else begin
         rel_valid <= due;
         if (due) begin
            rel_ctx    <= q_ctx[sel];
            rel_fin    <= q_fin[sel];
            q_v[sel]   <= 1'b0;
         end
         if (push) begin
            q_v[free_idx]   <= 1'b1;
            q_fin[free_idx] <= push_fin;
            q_ctx[free_idx] <= push_ctx;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R4

   AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> (rel_fin < now)); // R3

endmodule

// File: rtl/flit_done_tracker.sv
module flit_done_tracker
   import fct_pkg::*;
#(
   parameter int TAG_W   = 4,
   parameter int DEPTH   = 4,
   parameter int QDEPTH  = 4,
   parameter int T_W     = 16,
   parameter int LEN_W   = 12,
   parameter int ID_W    = 16,
   parameter int HOP_W   = 3,
   parameter int PLEN_W  = 3,
   parameter int OVH_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fl_valid,
   output logic              fl_ready,
   input  logic [TAG_W-1:0]  fl_tag,
   input  logic              fl_first,
   input  logic              fl_last,
   input  logic [T_W-1:0]    fl_finish,
   input  logic              fl_dma,
   input  logic              fl_bypass,
   input  logic              fl_write,
   input  logic [LEN_W-1:0]  fl_nbytes,
   input  logic [ID_W-1:0]   fl_ids,
   input  logic [PLEN_W-1:0] fl_hops,
   input  logic [HOP_W-1:0]  fl_next_hop,
   output logic              rsp_valid,
   output logic [1:0]        rsp_kind,
   output logic              rsp_fwd,
   output logic [HOP_W-1:0]  rsp_hop,
   output logic [LEN_W-1:0]  rsp_len,
   output logic [ID_W-1:0]   rsp_ids,
   output logic [TAG_W-1:0]  rsp_tag
);
   localparam int CTX_W = TAG_W + 4 + HOP_W + LEN_W + ID_W;

   if (T_W < 8) begin : g_bad_tw
      $error("flit_done_tracker: T_W too narrow");
   end

   logic [T_W-1:0]   now_q;
   logic             tbl_full, q_full, acc, short_path;
   logic [CTX_W-1:0] ctx_in, ret_ctx, rel_ctx;
   logic [T_W-1:0]   ret_fin;
   logic             rel_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= '0;
      else        now_q <= now_q + 1'b1;
   end

   assign short_path = (fl_hops < PLEN_W'(2));
   assign ctx_in = {fl_tag, fl_dma, fl_bypass, fl_write, short_path,
                    fl_next_hop, fl_nbytes, fl_ids};

   assign fl_ready = !(fl_first && !fl_last && tbl_full) && !(fl_last && q_full);
   assign acc      = fl_valid && fl_ready;

   fct_tag_table #(
      .TAG_W(TAG_W), .DEPTH(DEPTH), .T_W(T_W), .CTX_W(CTX_W), .OVH_CYC(OVH_CYC)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .now(now_q), .acc(acc), .tag(fl_tag),
      .first(fl_first), .last(fl_last), .fin(fl_finish), .ctx_in(ctx_in),
      .full(tbl_full), .ret_fin(ret_fin), .ret_ctx(ret_ctx)
   );

   fct_rsp_queue #(
      .QDEPTH(QDEPTH), .T_W(T_W), .CTX_W(CTX_W)
   ) u_queue (
      .clk(clk), .rst_n(rst_n), .now(now_q), .push(acc && fl_last),
      .push_fin(ret_fin), .push_ctx(ret_ctx), .full(q_full),
      .rel_valid(rel_valid), .rel_ctx(rel_ctx)
   );

   logic [TAG_W-1:0] u_tag;
   logic             u_dma, u_byp, u_wr, u_short;
   logic [HOP_W-1:0] u_hop;
   logic [LEN_W-1:0] u_len;
   logic [ID_W-1:0]  u_ids;
   rsp_kind_e        kind;

   assign {u_tag, u_dma, u_byp, u_wr, u_short, u_hop, u_len, u_ids} = rel_ctx;
   assign kind = pick_kind(u_dma, u_byp, u_wr);

   assign rsp_valid = rel_valid;
   assign rsp_kind  = kind;
   assign rsp_fwd   = (kind != RK_LOCAL) && !u_short;
   assign rsp_hop   = rsp_fwd ? u_hop : '0;
   assign rsp_len   = (kind == RK_RDATA) ? u_len : '0;
   assign rsp_ids   = (kind == RK_STATUS) ? u_ids : '0;
   assign rsp_tag   = u_tag;

   AST_LOCAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_kind == 2'd2)) |-> !rsp_fwd); // R7

   AST_DIRECT_NO_HOP: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fwd) |-> (rsp_hop == '0)); // R9

endmodule

// File: tb/flit_done_tracker_bench.sv
module flit_done_tracker_bench;
   localparam int OVH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fl_valid = 1'b0, fl_first = 1'b0, fl_last = 1'b0;
   logic        fl_dma = 1'b0, fl_bypass = 1'b0, fl_write = 1'b0;
   logic [3:0]  fl_tag = '0;
   logic [15:0] fl_finish = '0, fl_ids = '0;
   logic [11:0] fl_nbytes = '0;
   logic [2:0]  fl_hops = '0, fl_next_hop = '0;
   logic        fl_ready, rsp_valid, rsp_fwd;
   logic [1:0]  rsp_kind;
   logic [2:0]  rsp_hop;
   logic [11:0] rsp_len;
   logic [15:0] rsp_ids;
   logic [3:0]  rsp_tag;

   flit_done_tracker u_flit_done_tracker (
      .clk(clk), .rst_n(rst_n), .fl_valid(fl_valid), .fl_ready(fl_ready),
      .fl_tag(fl_tag), .fl_first(fl_first), .fl_last(fl_last),
      .fl_finish(fl_finish), .fl_dma(fl_dma), .fl_bypass(fl_bypass),
      .fl_write(fl_write), .fl_nbytes(fl_nbytes), .fl_ids(fl_ids),
      .fl_hops(fl_hops), .fl_next_hop(fl_next_hop), .rsp_valid(rsp_valid),
      .rsp_kind(rsp_kind), .rsp_fwd(rsp_fwd), .rsp_hop(rsp_hop),
      .rsp_len(rsp_len), .rsp_ids(rsp_ids), .rsp_tag(rsp_tag)
   );

   always #4 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   int lg_n = 0;
   int lg_cyc [64];
   int lg_kind[64], lg_tag[64], lg_fwd[64], lg_hop[64], lg_len[64], lg_ids[64];
   always @(negedge clk) begin
      if (rst_n && rsp_valid && lg_n < 64) begin
         lg_cyc[lg_n]  = cyc;
         lg_kind[lg_n] = rsp_kind;
         lg_tag[lg_n]  = rsp_tag;
         lg_fwd[lg_n]  = rsp_fwd;
         lg_hop[lg_n]  = rsp_hop;
         lg_len[lg_n]  = rsp_len;
         lg_ids[lg_n]  = rsp_ids;
         lg_n = lg_n + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_cyc(input int t, input int fin);
      int e;
      e = t + OVH;
      if (fin > e) e = fin;
      if (t + 1 > e) e = t + 1;
      return e + 1;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Drive a flit; delta is added to the cycle count at drive time.
   task automatic send(input int tag, input bit first, input bit last, input int delta,
                       input bit dma, input bit byp, input bit wr, input int hops,
                       input int nb, input int ids, input int hop,
                       output int t_acc, output int fin_abs);
      int guard;
      @(negedge clk);
      fin_abs     = cyc + delta;
      fl_tag      = 4'(tag);
      fl_first    = first;
      fl_last     = last;
      fl_finish   = 16'(fin_abs);
      fl_dma      = dma;
      fl_bypass   = byp;
      fl_write    = wr;
      fl_hops     = 3'(hops);
      fl_nbytes   = 12'(nb);
      fl_ids      = 16'(ids);
      fl_next_hop = 3'(hop);
      fl_valid    = 1'b1;
      #1;
      guard = 0;
      while (!fl_ready && guard < 100) begin
         @(negedge clk);
         #1;
         guard++;
      end
      t_acc = cyc;
      @(posedge clk);
      #1;
      fl_valid = 1'b0;
   endtask

   task automatic wait_log(input int want);
      int guard = 0;
      while (lg_n < want && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      #1;
   endtask

   typedef struct packed {
      logic        dma, byp, wr;
      logic [2:0]  hops;
      logic [11:0] nb;
      logic [15:0] ids;
      logic [2:0]  hop;
      logic [7:0]  delta;
      logic [1:0]  ekind;
      logic        efwd;
      logic [11:0] elen;
      logic [15:0] eids;
      logic [2:0]  ehop;
   } vec_t;

   // R5..R9 and R1 (last row: finish already past, overhead dominates)
   localparam vec_t VEC [7] = '{
      '{1'b1, 1'b0, 1'b0, 3'd3, 12'd64,  16'h1111, 3'd5, 8'd5, 2'd0, 1'b1, 12'd0,   16'h0000, 3'd5},
      '{1'b1, 1'b1, 1'b1, 3'd2, 12'd32,  16'h2222, 3'd2, 8'd7, 2'd0, 1'b1, 12'd0,   16'h0000, 3'd2},
      '{1'b0, 1'b1, 1'b0, 3'd4, 12'd200, 16'h3333, 3'd6, 8'd4, 2'd1, 1'b1, 12'd200, 16'h0000, 3'd6},
      '{1'b0, 1'b1, 1'b1, 3'd3, 12'd96,  16'h4444, 3'd3, 8'd6, 2'd2, 1'b0, 12'd0,   16'h0000, 3'd0},
      '{1'b0, 1'b0, 1'b0, 3'd2, 12'd16,  16'hBEEF, 3'd1, 8'd3, 2'd3, 1'b1, 12'd0,   16'hBEEF, 3'd1},
      '{1'b0, 1'b0, 1'b1, 3'd1, 12'd8,   16'h1234, 3'd7, 8'd5, 2'd3, 1'b0, 12'd0,   16'h1234, 3'd0},
      '{1'b1, 1'b0, 1'b1, 3'd0, 12'd40,  16'h5555, 3'd4, 8'd0, 2'd0, 1'b0, 12'd0,   16'h0000, 3'd0}
   };

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int t0, t1, t2, ta, tb, tc, td, te, f0, f1, f2, fa, fb, fc, fd, fe, base, tx, fx;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R12 ready after reset", fl_ready, 1);
      check("R12 no response after reset", rsp_valid, 0);

      // Vector table: single-flit transactions, one at a time
      for (int i = 0; i < 7; i++) begin
         base = lg_n;
         send(i, 1, 1, VEC[i].delta, VEC[i].dma, VEC[i].byp, VEC[i].wr, VEC[i].hops,
              VEC[i].nb, VEC[i].ids, VEC[i].hop, tx, fx);
         wait_log(base + 1);
         check("R3 release cycle (R1 overhead)", lg_cyc[base], exp_cyc(tx, fx));
         check("R3 handle tag", lg_tag[base], i);
         check("R5 R6 R7 R8 kind", lg_kind[base], VEC[i].ekind);
         check("R9 forward flag", lg_fwd[base], VEC[i].efwd);
         check("R9 reverse hop", lg_hop[base], VEC[i].ehop);
         check("R6 data length", lg_len[base], VEC[i].elen);
         check("R8 identity word", lg_ids[base], VEC[i].eids);
      end

      // R1 R2: three-flit transaction, the middle flit finishes last
      base = lg_n;
      send(3, 1, 0, 1, 0, 0, 0, 3, 24, 16'h0A0A, 2, t0, f0);
      send(3, 0, 0, 9, 0, 0, 0, 3, 24, 16'h0A0A, 2, t1, f1);
      send(3, 0, 1, 2, 0, 0, 0, 3, 24, 16'h0A0A, 2, t2, f2);
      wait_log(base + 1);
      begin
         int lf = t0 + OVH;
         if (f0 > lf) lf = f0;
         if (f1 > lf) lf = f1;
         if (f2 > lf) lf = f2;
         check("R2 running max finish", lg_cyc[base], exp_cyc(t2, lf));
      end
      check("R8 multi-flit kind", lg_kind[base], 3);

      // R4 R11: back-to-back singles, released by finish order
      base = lg_n;
      send(1, 1, 1, 20, 0, 0, 0, 2, 4, 16'h0001, 1, ta, fa);
      send(2, 1, 1, 8,  0, 0, 0, 2, 4, 16'h0002, 1, tb, fb);
      send(4, 1, 1, 14, 0, 0, 0, 2, 4, 16'h0003, 1, tc, fc);
      check("R4 intake not stalled (2nd)", tb, ta + 1);
      check("R4 intake not stalled (3rd)", tc, ta + 2);
      wait_log(base + 3);
      check("R11 first released tag", lg_tag[base], 2);
      check("R11 second released tag", lg_tag[base + 1], 4);
      check("R11 third released tag", lg_tag[base + 2], 1);
      check("R3 overlap release b", lg_cyc[base], exp_cyc(tb, fb));
      check("R3 overlap release c", lg_cyc[base + 1], exp_cyc(tc, fc));
      check("R3 overlap release a", lg_cyc[base + 2], exp_cyc(ta, fa));

      // R11: equal finish times, one release per cycle
      base = lg_n;
      send(5, 1, 1, 10, 0, 0, 0, 2, 4, 16'h0005, 1, td, fd);
      send(6, 1, 1, 9,  0, 0, 0, 2, 4, 16'h0006, 1, te, fe);
      check("R11 equal finish setup", fe, fd);
      wait_log(base + 2);
      check("R11 first of tie", lg_cyc[base], fd + 1);
      check("R11 second of tie", lg_cyc[base + 1], fd + 2);

      // R10: full tag table
      base = lg_n;
      for (int k = 0; k < 4; k++) send(8 + k, 1, 0, 1, 0, 0, 1, 3, 4, 16'h0100 + k, 2, tx, fx);
      @(negedge clk);
      fl_tag = 4'd12; fl_first = 1'b1; fl_last = 1'b0; fl_valid = 1'b1;
      fl_finish = 16'(cyc + 1);
      #1;
      check("R10 first flit refused when full", fl_ready, 0);
      fl_first = 1'b0; fl_last = 1'b1; fl_tag = 4'd8;
      #1;
      check("R10 continuation accepted when full", fl_ready, 1);
      fl_valid = 1'b0;
      send(8, 0, 1, 1, 0, 0, 1, 3, 4, 16'h0100, 2, tx, fx);
      @(negedge clk);
      fl_tag = 4'd12; fl_first = 1'b1; fl_last = 1'b0;
      #1;
      check("R10 first flit accepted after slot freed", fl_ready, 1);
      send(12, 1, 0, 1, 0, 0, 1, 3, 4, 16'h0104, 2, tx, fx);
      for (int k = 9; k < 13; k++) send(k, 0, 1, 1, 0, 0, 1, 3, 4, 16'h0, 2, tx, fx);
      wait_log(base + 5);
      repeat (10) @(negedge clk);
      check("R3 all retired entries answered", lg_n - base, 5);
      check("R8 status ids carried", lg_ids[base], 16'h0100);

      finish_run();
   end
endmodule